// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block receives configuration words over a three-wire serial link (serial clock, serial data, load strobe) and turns them into decoded control fields for a frequency-synthesis datapath. The three serial inputs are asynchronous to the system clock. They are brought into the system clock domain, and the block detects their edges there. Each rising edge of the serial clock shifts one data bit into an 18-bit word, most significant bit first. A rising edge of the load strobe then commits that word to one of two holding registers.

The final bit shifted in (word bit 0) is the target selector. A 0 selects the divider register, which carries a 10-bit main count, a 5-bit swallow count, a counter-reset bit and a power-down bit. A 1 selects the reference register, which carries a 10-bit reference ratio, a test bit, a reserved bit, a polarity bit and an output tri-state bit. Values that the downstream counters cannot use are still latched unchanged, but they set a sticky error flag. Loading keeps working whatever the power-down and counter-reset bits hold.

A three-state controller sequences the commit. In `ST_IDLE` it waits for a strobe rising edge and moves to `ST_COMMIT`. `ST_COMMIT` writes the selected register for one cycle. From there the controller goes to `ST_HOLD` while the strobe stays high, or straight back to `ST_IDLE` if the strobe has already fallen. `ST_HOLD` returns to `ST_IDLE` once the strobe falls.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset every decoded field and the error flag read 0.
- R2: On each serial clock rising edge, the serial data bit enters word bit 0 and earlier bits move one place toward bit 17, so the first bit sent ends at bit 17.
- R3: A commit with word bit 0 = 0 loads the divider register: main count = bits 17..8, swallow count = bits 7..3, counter reset = bit 2, power down = bit 1. The reference fields are left unchanged.
- R4: A commit with word bit 0 = 1 loads the reference register: ratio = bits 10..1, tri-state = bit 11, polarity = bit 12, reserved = bit 13, test = bit 14. Bits 17..15 are ignored, and the divider fields are left unchanged.
- R5: Shifting words without a strobe rising edge changes no decoded field.
- R6: A reference commit with ratio below 2 sets the error flag, and the ratio is still latched as sent.
- R7: A divider commit with main count below 3, or main count not greater than swallow count, sets the error flag, and the values are still latched as sent.
- R8: Once set, the error flag stays at 1 across later legal commits until reset.
- R9: Words are still loaded while the divider register holds power down = 1 and/or counter reset = 1.
- R10: While the strobe stays high, further serial clock edges shift but commit nothing. The next commit needs the strobe to fall and rise again.
- R11: A serial clock rising edge that arrives together with the strobe rising edge is included in the committed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe; rising edge commits |
| ref_ratio | output | 10 | Reference divide ratio |
| ref_test | output | 1 | Test mode bit |
| ref_rsv | output | 1 | Reserved bit as written |
| ref_pol | output | 1 | Phase polarity bit |
| ref_tri | output | 1 | Output tri-state bit |
| div_main | output | 10 | Main (B) count |
| div_swallow | output | 5 | Swallow (A) count |
| div_cnt_rst | output | 1 | Counter reset bit |
| div_pwdn | output | 1 | Power-down bit |
| cfg_err | output | 1 | Sticky illegal-value flag |

## Verification
A shift and a commit can fall in the same system cycle when the serial clock and the strobe rise together. Both inputs pass through synchronizers of equal depth, so the bit shift and the strobe edge are detected in one cycle. The bench provokes this by sending seventeen bits normally and then raising the serial clock and the strobe together with the last bit. It judges the result by checking that the committed fields match the complete 18-bit word, including the final address bit, and not the word shifted by one place.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
    localparam int WORD_W   = 18;
    localparam int RATIO_W  = 10;
    localparam int MAIN_W   = 10;
    localparam int SWAL_W   = 5;
    localparam int MIN_RATIO = 2;
    localparam int MIN_MAIN  = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_HOLD   = 2'd2
    } load_state_t;
endpackage

// File: rtl/cfg_in_sync.sv
module cfg_in_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter
    import cfg_loader_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdata_s,
    output logic [WORD_W-1:0] word
);
    logic sclk_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            word   <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (sclk_s && !sclk_d)
                word <= {word[WORD_W-2:0], sdata_s};
        end
    end
endmodule

// File: rtl/cfg_field_regs.sv
module cfg_field_regs
    import cfg_loader_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic [WORD_W-1:0]  word,
    output logic [RATIO_W-1:0] ref_ratio,
    output logic               ref_test,
    output logic               ref_rsv,
    output logic               ref_pol,
    output logic               ref_tri,
    output logic [MAIN_W-1:0]  div_main,
    output logic [SWAL_W-1:0]  div_swallow,
    output logic               div_cnt_rst,
    output logic               div_pwdn,
    output logic               cfg_err
);
    localparam int MAIN_LSB = WORD_W - MAIN_W;
    localparam int SWAL_LSB = MAIN_LSB - SWAL_W;

    logic               sel_ref;
    logic [RATIO_W-1:0] w_ratio;
    logic [MAIN_W-1:0]  w_main;
    logic [SWAL_W-1:0]  w_swal;
    logic               bad_ref;
    logic               bad_div;

    always_comb begin
        sel_ref = word[0];
        w_ratio = word[RATIO_W:1];
        w_main  = word[WORD_W-1:MAIN_LSB];
        w_swal  = word[MAIN_LSB-1:SWAL_LSB];
        bad_ref = (w_ratio < RATIO_W'(MIN_RATIO));
        bad_div = (w_main < MAIN_W'(MIN_MAIN)) ||
                  (w_main <= MAIN_W'(w_swal));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_ratio   <= '0;
            ref_test    <= 1'b0;
            ref_rsv     <= 1'b0;
            ref_pol     <= 1'b0;
            ref_tri     <= 1'b0;
            div_main    <= '0;
            div_swallow <= '0;
            div_cnt_rst <= 1'b0;
            div_pwdn    <= 1'b0;
            cfg_err     <= 1'b0;
        end else if (commit) begin
            if (sel_ref) begin
                ref_ratio <= w_ratio;
                ref_tri   <= word[RATIO_W+1];
                ref_pol   <= word[RATIO_W+2];
                ref_rsv   <= word[RATIO_W+3];
                ref_test  <= word[RATIO_W+4];
                if (bad_ref) cfg_err <= 1'b1;
            end else begin
                div_main    <= w_main;
                div_swallow <= w_swal;
                div_cnt_rst <= word[2];
                div_pwdn    <= word[1];
                if (bad_div) cfg_err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfg_loader_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_data,
    input  logic               ser_load,
    output logic [RATIO_W-1:0] ref_ratio,
    output logic               ref_test,
    output logic               ref_rsv,
    output logic               ref_pol,
    output logic               ref_tri,
    output logic [MAIN_W-1:0]  div_main,
    output logic [SWAL_W-1:0]  div_swallow,
    output logic               div_cnt_rst,
    output logic               div_pwdn,
    output logic               cfg_err
);
    logic [2:0]        pins_s;
    logic              sclk_s, sdata_s, load_s, load_d, load_rise;
    logic [WORD_W-1:0] word;
    logic              commit;
    load_state_t       state, state_nx;

    cfg_in_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_load, ser_data, ser_clk}),
        .sync_out (pins_s)
    );

    assign sclk_s  = pins_s[0];
    assign sdata_s = pins_s[1];
    assign load_s  = pins_s[2];

    cfg_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sclk_s),
        .sdata_s (sdata_s),
        .word    (word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) load_d <= 1'b0;
        else        load_d <= load_s;
    end
    assign load_rise = load_s && !load_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (load_rise) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = load_s ? ST_HOLD : ST_IDLE;
            ST_HOLD:   if (!load_s) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        commit = 1'b0;
        unique case (state)
            ST_IDLE:   commit = 1'b0;
            ST_COMMIT: commit = 1'b1;
            ST_HOLD:   commit = 1'b0;
            default:   commit = 1'b0;
        endcase
    end

    cfg_field_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .word        (word),
        .ref_ratio   (ref_ratio),
        .ref_test    (ref_test),
        .ref_rsv     (ref_rsv),
        .ref_pol     (ref_pol),
        .ref_tri     (ref_tri),
        .div_main    (div_main),
        .div_swallow (div_swallow),
        .div_cnt_rst (div_cnt_rst),
        .div_pwdn    (div_pwdn),
        .cfg_err     (cfg_err)
    );
endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk
    import cfg_loader_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               commit,
    input logic [WORD_W-1:0]  word,
    input logic [RATIO_W-1:0] ref_ratio,
    input logic               ref_pol,
    input logic               ref_tri,
    input logic [MAIN_W-1:0]  div_main,
    input logic [SWAL_W-1:0]  div_swallow,
    input logic               div_pwdn,
    input logic               cfg_err
);
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    a_r3_ref_kept_on_div_load: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !word[0]) |=> ($stable(ref_ratio) && $stable(ref_pol) && $stable(ref_tri)));

    a_r4_div_kept_on_ref_load: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && word[0]) |=> ($stable(div_main) && $stable(div_swallow) && $stable(div_pwdn)));

    a_r5_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(ref_ratio) && $stable(div_main) && $stable(div_swallow)));

    a_r6_low_ratio_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && word[0] && (word[RATIO_W:1] < RATIO_W'(MIN_RATIO))) |=> cfg_err);

    a_r7_bad_main_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !word[0] &&
         ((word[WORD_W-1:WORD_W-MAIN_W] < MAIN_W'(MIN_MAIN)) ||
          (word[WORD_W-1:WORD_W-MAIN_W] <= MAIN_W'(word[WORD_W-MAIN_W-1:WORD_W-MAIN_W-SWAL_W]))))
        |=> cfg_err);
endmodule

bind cfg_serial_loader cfg_serial_loader_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit),
    .word        (word),
    .ref_ratio   (ref_ratio),
    .ref_pol     (ref_pol),
    .ref_tri     (ref_tri),
    .div_main    (div_main),
    .div_swallow (div_swallow),
    .div_pwdn    (div_pwdn),
    .cfg_err     (cfg_err)
);

// File: tb/test_cfg_serial_loader.sv
module test_cfg_serial_loader;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
    logic [9:0] ref_ratio, div_main;
    logic [4:0] div_swallow;
    logic ref_test, ref_rsv, ref_pol, ref_tri, div_cnt_rst, div_pwdn, cfg_err;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [9:0] e_ratio, e_main;
    logic [4:0] e_swal;
    logic e_test, e_rsv, e_pol, e_tri, e_crst, e_pd, e_err;

    always #5 clk = ~clk;

    cfg_serial_loader i_cfg_serial_loader (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load(ser_load), .ref_ratio(ref_ratio), .ref_test(ref_test),
        .ref_rsv(ref_rsv), .ref_pol(ref_pol), .ref_tri(ref_tri),
        .div_main(div_main), .div_swallow(div_swallow),
        .div_cnt_rst(div_cnt_rst), .div_pwdn(div_pwdn), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        e_ratio = '0; e_main = '0; e_swal = '0;
        e_test = 0; e_rsv = 0; e_pol = 0; e_tri = 0; e_crst = 0; e_pd = 0; e_err = 0;
    endtask

    function automatic bit bad_word(input logic [17:0] w);
        if (w[0]) return (w[10:1] < 10'd2);
        return (w[17:8] < 10'd3) || (w[17:8] <= {5'd0, w[7:3]});
    endfunction

    task automatic model_apply(input logic [17:0] w);
        if (w[0]) begin
            e_ratio = w[10:1]; e_tri = w[11]; e_pol = w[12]; e_rsv = w[13]; e_test = w[14];
        end else begin
            e_main = w[17:8]; e_swal = w[7:3]; e_crst = w[2]; e_pd = w[1];
        end
        if (bad_word(w)) e_err = 1;
    endtask

    task automatic check_all(input string req);
        chk(req, "ref_ratio", ref_ratio, e_ratio);
        chk(req, "ref_test", ref_test, e_test);
        chk(req, "ref_rsv", ref_rsv, e_rsv);
        chk(req, "ref_pol", ref_pol, e_pol);
        chk(req, "ref_tri", ref_tri, e_tri);
        chk(req, "div_main", div_main, e_main);
        chk(req, "div_swallow", div_swallow, e_swal);
        chk(req, "div_cnt_rst", div_cnt_rst, e_crst);
        chk(req, "div_pwdn", div_pwdn, e_pd);
        chk(req, "cfg_err", cfg_err, e_err);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        ser_data = b; wait_clk(3);
        ser_clk = 1; wait_clk(3);
        ser_clk = 0; wait_clk(2);
    endtask

    task automatic shift_word(input logic [17:0] w);
        for (int i = 17; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic strobe();
        ser_load = 1; wait_clk(5);
        ser_load = 0; wait_clk(5);
    endtask

    task automatic send(input logic [17:0] w, input string req);
        shift_word(w);
        strobe();
        model_apply(w);
        check_all(req);
    endtask

    task automatic do_reset();
        rst_n = 0; ser_clk = 0; ser_data = 0; ser_load = 0;
        wait_clk(5);
        rst_n = 1; wait_clk(3);
        model_clear();
    endtask

    function automatic logic [17:0] mk_div(input logic [9:0] b, input logic [4:0] a,
                                           input logic cr, input logic pd);
        return {b, a, cr, pd, 1'b0};
    endfunction

    function automatic logic [17:0] mk_ref(input logic [2:0] x, input logic t, input logic rs,
                                           input logic p, input logic tr, input logic [9:0] r);
        return {x, t, rs, p, tr, r, 1'b1};
    endfunction

    initial begin
        void'($urandom(32'd7071));
        do_reset();
        check_all("R1");

        // R2/R3: divider load, MSB-first placement
        send(mk_div(10'd517, 5'd19, 1'b0, 1'b0), "R3");
        // R2/R4: reference load, ignored top bits set
        send(mk_ref(3'b111, 1'b0, 1'b0, 1'b1, 1'b0, 10'd650), "R4");
        send(mk_ref(3'b000, 1'b1, 1'b1, 1'b0, 1'b1, 10'd2), "R2");

        // R5: shift without strobe
        shift_word(mk_div(10'd100, 5'd3, 1'b1, 1'b1));
        wait_clk(6);
        check_all("R5");

        // R11: last serial edge together with strobe rise
        begin
            logic [17:0] w;
            w = mk_ref(3'b010, 1'b0, 1'b0, 1'b1, 1'b1, 10'd333);
            for (int i = 17; i >= 1; i--) shift_bit(w[i]);
            ser_data = w[0]; wait_clk(3);
            ser_clk = 1; ser_load = 1; wait_clk(5);
            ser_clk = 0; ser_load = 0; wait_clk(5);
            model_apply(w);
            check_all("R11");
        end

        // R9: power-down modes do not block loading
        send(mk_div(10'd40, 5'd7, 1'b0, 1'b1), "R9");
        send(mk_ref(3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 10'd77), "R9");
        send(mk_div(10'd41, 5'd8, 1'b1, 1'b1), "R9");
        send(mk_div(10'd42, 5'd9, 1'b1, 1'b0), "R9");

        // R10: strobe held high blocks a second commit
        begin
            logic [17:0] w1, w2;
            w1 = mk_div(10'd300, 5'd10, 1'b0, 1'b0);
            w2 = mk_div(10'd600, 5'd20, 1'b0, 1'b0);
            shift_word(w1);
            ser_load = 1; wait_clk(5);
            model_apply(w1);
            shift_word(w2);
            wait_clk(4);
            check_all("R10");
            ser_load = 0; wait_clk(5);
            strobe();
            model_apply(w2);
            check_all("R10");
        end

        // random traffic
        for (int k = 0; k < 30; k++) begin
            logic [17:0] w;
            w = 18'($urandom());
            send(w, w[0] ? "R4" : "R3");
        end

        // R6/R7/R8 from a clean state
        do_reset();
        check_all("R1");
        send(mk_ref(3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 10'd1), "R6");
        do_reset();
        send(mk_ref(3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 10'd0), "R6");
        do_reset();
        send(mk_div(10'd2, 5'd0, 1'b0, 1'b0), "R7");
        do_reset();
        send(mk_div(10'd12, 5'd12, 1'b0, 1'b0), "R7");
        do_reset();
        send(mk_div(10'd13, 5'd12, 1'b0, 1'b0), "R7");
        send(mk_div(10'd3, 5'd2, 1'b0, 1'b0), "R7");
        send(mk_ref(3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 10'd2), "R6");
        send(mk_div(10'd5, 5'd9, 1'b0, 1'b0), "R8");
        send(mk_div(10'd900, 5'd1, 1'b0, 1'b0), "R8");
        send(mk_ref(3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 10'd1000), "R8");
        do_reset();
        check_all("R8");

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule